// File: doc/BRIEF.md
# Packed-Syllable Instruction Sequencer

This block is the front end of a stack machine whose instruction words come in two usable shapes. It fetches 32-bit words from an instruction memory port, with at most one fetch outstanding, and sorts each word by its top two bits. A word with bit 31 set carries a 31-bit constant. The sequencer turns it into one literal-push item whose value is that constant moved up one place, with a zero in bit 0. A word whose top bits are `00` holds five 6-bit syllables, and the sequencer hands them out one at a time, starting with the most significant. A word whose top bits are `01` has no defined meaning. It raises an illegal flag and issue stops.

Items leave through a valid/ready handshake. Alongside each item the block reports the word pointer and the syllable counter. Both point at what comes next: the pointer holds the address after the word being issued, and the counter holds the position of the next syllable, which wraps to 0 after the fifth. The execution side can redirect the sequencer at any time. A redirect loads a new word address and throws away whatever is left of the current word, along with any fetch still in flight. It also restarts a sequencer that a HALT syllable or an illegal word has stopped.

Top module: `pack_seq`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o`, `imem_req_o`, `halted_o` and `illegal_o` are 0, `pc_o` equals `RESET_PC` and `sc_o` is 0. The first fetch after reset reads `RESET_PC`.
- R2: No more than one fetch is ever outstanding, and no fetch is issued while an item is being offered. Each fetch reads `pc_o`, after which `pc_o` moves up by 4. Fetches follow consecutive word addresses until a redirect occurs.
- R3: A word with bit 31 = 1 produces exactly one item, with `out_is_lit_o` = 1 and `out_lit_o` equal to the word's bits 30..0 followed by a zero bit.
- R4: A word with bits 31..30 = `00` produces five items with `out_is_lit_o` = 0. `out_syl_o` carries bits 29..24 first, then 23..18, 17..12 and 11..6, and bits 5..0 last.
- R5: While an item from the word at address A is offered, `pc_o` = A+4. `sc_o` is 0 for a literal. For the syllable at 0-based position k, `sc_o` is (k+1) mod 5, so the third syllable of the word at 0x204 shows pc 0x208 and sc 3.
- R6: While `out_valid_o` = 1 and `out_ready_i` = 0, and no redirect is present, the offered item stays valid and does not change on the next cycle.
- R7: The syllable `000000` is issued. From the next cycle on, `halted_o` = 1 and no item and no fetch appear until a redirect.
- R8: A word with bits 31..30 = `01` issues nothing. From the cycle after its arrival, `illegal_o` = 1 and no item and no fetch appear until a redirect.
- R9: A redirect in cycle t makes `pc_o` equal the target in cycle t+1. It drops the rest of the current word and any fetch response still in flight, and it clears `halted_o` and `illegal_o`. Issue then resumes from the target with `sc_o` following R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_req_o | output | 1 | Fetch request, always accepted by the memory |
| imem_addr_o | output | 32 | Fetch word address |
| imem_rvalid_i | input | 1 | Fetch response strobe |
| imem_rdata_i | input | 32 | Fetched instruction word |
| redir_valid_i | input | 1 | Branch redirect strobe from execution |
| redir_pc_i | input | 32 | Redirect target address |
| out_valid_o | output | 1 | An item is offered |
| out_ready_i | input | 1 | Consumer takes the offered item |
| out_is_lit_o | output | 1 | 1 for a literal push, 0 for a syllable |
| out_syl_o | output | 6 | Offered syllable |
| out_lit_o | output | 32 | Offered literal value, meaningful when out_is_lit_o is 1 |
| pc_o | output | 32 | Address of the next word |
| sc_o | output | 3 | Index of the next syllable, 0 to 4 |
| halted_o | output | 1 | Stopped by a HALT syllable |
| illegal_o | output | 1 | Stopped by a reserved-format word |

## Verification
The assertions assume that the memory asserts `imem_rvalid_i` only while a fetch is outstanding, and that it answers each accepted request exactly once. The bench memory records every request it sees and replies after one to three cycles. It never replies without a request, and it keeps replying to requests that a redirect has cancelled, so that the drop path is exercised. Redirects are driven only with `out_ready_i` low, so a consumed item and a redirect never fall in the same cycle. The stall-hold property is therefore checked only in cycles without a redirect.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W  = 32;
  localparam int SYL_W   = 6;
  localparam int NUM_SYL = 5;
  localparam int PACK_W  = SYL_W * NUM_SYL;
  localparam int SC_W    = $clog2(NUM_SYL);

  typedef enum logic [1:0] {
    FMT_PACKED = 2'd0,
    FMT_RSVD   = 2'd1,
    FMT_LIT    = 2'd2
  } fmt_e;

  localparam logic [SYL_W-1:0] SYL_HALT = '0;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fmt_e              fmt_o,
  output logic [WORD_W-1:0] data_o
);
  always_comb begin
    if (word_i[WORD_W-1]) begin
      fmt_o  = FMT_LIT;
      data_o = {word_i[WORD_W-2:0], 1'b0};
    end else if (word_i[WORD_W-2]) begin
      fmt_o  = FMT_RSVD;
      data_o = word_i;
    end else begin
      fmt_o  = FMT_PACKED;
      data_o = word_i;
    end
  end
endmodule

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = 32'h0000_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_en_i,
  input  logic              redir_i,
  input  logic [WORD_W-1:0] redir_pc_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              rsp_take_o
);
  logic              run_q, pend_q, drop_q;
  logic [WORD_W-1:0] pc_q;

  // request depends on registers only
  assign req_o      = run_q && fetch_en_i && !pend_q;
  assign pc_o       = pc_q;
  assign rsp_take_o = rvalid_i && pend_q && !drop_q && !redir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      pc_q   <= RESET_PC;
    end else begin
      run_q <= 1'b1;
      if (req_o)         pend_q <= 1'b1;
      else if (rvalid_i) pend_q <= 1'b0;
      // a redirect orphans the in-flight (or just issued) fetch
      if (redir_i && (req_o || (pend_q && !rvalid_i))) drop_q <= 1'b1;
      else if (rvalid_i)                                drop_q <= 1'b0;
      if (redir_i)    pc_q <= redir_pc_i;
      else if (req_o) pc_q <= pc_q + WORD_W'(4);
    end
  end

  AST_RSP_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> pend_q); // R2
  AST_REDIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> pc_o == $past(redir_pc_i)); // R9
  AST_FETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !redir_i |=> pend_q && pc_o == $past(pc_o) + WORD_W'(4)); // R2
endmodule

// File: rtl/seq_issue.sv
module seq_issue
  import seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_take_i,
  input  fmt_e              rsp_fmt_i,
  input  logic [WORD_W-1:0] rsp_data_i,
  input  logic              redir_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic              out_is_lit_o,
  output logic [SYL_W-1:0]  out_syl_o,
  output logic [WORD_W-1:0] out_lit_o,
  output logic [SC_W-1:0]   sc_o,
  output logic              halted_o,
  output logic              illegal_o,
  output logic              fetch_en_o
);
  logic              buf_vld_q, is_lit_q, halt_q, ill_q;
  logic [WORD_W-1:0] data_q;
  logic [SC_W-1:0]   idx_q;
  logic              fire, last;
  logic [SYL_W-1:0]  cur_syl;

  // syllables shift toward the top slice; no index mux on the output
  assign cur_syl = data_q[PACK_W-1 -: SYL_W];
  assign last    = (idx_q == SC_W'(NUM_SYL - 1));
  assign fire    = buf_vld_q && out_ready_i;

  assign out_valid_o  = buf_vld_q;
  assign out_is_lit_o = is_lit_q;
  assign out_syl_o    = cur_syl;
  assign out_lit_o    = data_q;
  assign halted_o     = halt_q;
  assign illegal_o    = ill_q;
  assign fetch_en_o   = !buf_vld_q && !halt_q && !ill_q;

  always_comb begin
    if (buf_vld_q && !is_lit_q) sc_o = last ? '0 : idx_q + SC_W'(1);
    else                        sc_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_vld_q <= 1'b0;
      is_lit_q  <= 1'b0;
      halt_q    <= 1'b0;
      ill_q     <= 1'b0;
      data_q    <= '0;
      idx_q     <= '0;
    end else if (redir_i) begin
      buf_vld_q <= 1'b0;
      halt_q    <= 1'b0;
      ill_q     <= 1'b0;
      idx_q     <= '0;
    end else if (rsp_take_i) begin
      idx_q <= '0;
      unique case (rsp_fmt_i)
        FMT_LIT: begin
          buf_vld_q <= 1'b1;
          is_lit_q  <= 1'b1;
          data_q    <= rsp_data_i;
        end
        FMT_PACKED: begin
          buf_vld_q <= 1'b1;
          is_lit_q  <= 1'b0;
          data_q    <= rsp_data_i;
        end
        default: ill_q <= 1'b1;
      endcase
    end else if (fire) begin
      if (is_lit_q) begin
        buf_vld_q <= 1'b0;
      end else if (cur_syl == SYL_HALT) begin
        buf_vld_q <= 1'b0;
        halt_q    <= 1'b1;
      end else if (last) begin
        buf_vld_q <= 1'b0;
        idx_q     <= '0;
      end else begin
        idx_q  <= idx_q + SC_W'(1);
        data_q <= data_q << SYL_W;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !redir_i |=> out_valid_o && $stable(out_is_lit_o) && $stable(out_lit_o) && $stable(sc_o)); // R6
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !redir_i |=> halted_o && !out_valid_o); // R7
  AST_ILL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !out_valid_o); // R8
  AST_SC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_o < SC_W'(NUM_SYL)); // R5
  AST_REDIR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> !out_valid_o && !halted_o && !illegal_o); // R9
endmodule

// File: rtl/pack_seq.sv
module pack_seq
  import seq_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0200
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        imem_req_o,
  output logic [31:0] imem_addr_o,
  input  logic        imem_rvalid_i,
  input  logic [31:0] imem_rdata_i,
  input  logic        redir_valid_i,
  input  logic [31:0] redir_pc_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic        out_is_lit_o,
  output logic [5:0]  out_syl_o,
  output logic [31:0] out_lit_o,
  output logic [31:0] pc_o,
  output logic [2:0]  sc_o,
  output logic        halted_o,
  output logic        illegal_o
);
  logic              fetch_en, rsp_take;
  fmt_e              rsp_fmt;
  logic [WORD_W-1:0] rsp_data;

  seq_fetch #(.RESET_PC(RESET_PC)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_en_i (fetch_en),
    .redir_i    (redir_valid_i),
    .redir_pc_i (redir_pc_i),
    .rvalid_i   (imem_rvalid_i),
    .req_o      (imem_req_o),
    .pc_o       (pc_o),
    .rsp_take_o (rsp_take)
  );
  assign imem_addr_o = pc_o;

  seq_decode u_decode (
    .word_i (imem_rdata_i),
    .fmt_o  (rsp_fmt),
    .data_o (rsp_data)
  );

  seq_issue u_issue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rsp_take_i   (rsp_take),
    .rsp_fmt_i    (rsp_fmt),
    .rsp_data_i   (rsp_data),
    .redir_i      (redir_valid_i),
    .out_ready_i  (out_ready_i),
    .out_valid_o  (out_valid_o),
    .out_is_lit_o (out_is_lit_o),
    .out_syl_o    (out_syl_o),
    .out_lit_o    (out_lit_o),
    .sc_o         (sc_o),
    .halted_o     (halted_o),
    .illegal_o    (illegal_o),
    .fetch_en_o   (fetch_en)
  );

  AST_STOP_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || illegal_o) |-> !imem_req_o); // R7
  AST_NO_PREFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !imem_req_o); // R2
endmodule

// File: tb/tb_pack_seq.sv
`timescale 1ns/1ps
module tb_pack_seq;
  localparam logic [31:0] BASE = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req, imem_rvalid = 1'b0, redir_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] imem_addr, imem_rdata = '0, redir_pc = '0;
  logic        out_valid, out_is_lit, halted, illegal;
  logic [5:0]  out_syl;
  logic [31:0] out_lit, pc;
  logic [2:0]  sc;

  always #2.5 clk = ~clk;

  pack_seq #(.RESET_PC(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_req_o(imem_req), .imem_addr_o(imem_addr),
    .imem_rvalid_i(imem_rvalid), .imem_rdata_i(imem_rdata),
    .redir_valid_i(redir_valid), .redir_pc_i(redir_pc),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_is_lit_o(out_is_lit), .out_syl_o(out_syl), .out_lit_o(out_lit),
    .pc_o(pc), .sc_o(sc), .halted_o(halted), .illegal_o(illegal)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [64];

  // reference model state
  logic [31:0] m_pc;
  int          m_idx;
  bit          m_halt, m_ill;
  // memory model state
  bit          mb_busy, mb_drop, first_req;
  int          mb_cnt;
  logic [31:0] mb_addr, exp_fetch;
  // redirect / hold bookkeeping
  bit          jmp_pend, chk_redir, hold_chk;
  logic [31:0] jmp_tgt, redir_prev;
  int          stop_cnt, idle;
  logic        h_lit;
  logic [5:0]  h_syl;
  logic [31:0] h_val;
  logic [2:0]  h_sc;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack5(logic [5:0] a, logic [5:0] b, logic [5:0] c,
                                        logic [5:0] d, logic [5:0] e);
    return {2'b00, a, b, c, d, e};
  endfunction

  function automatic logic [31:0] jmp_target(logic [31:0] waddr);
    case (waddr[7:2])
      6'd2:    return BASE + 32'd24;
      6'd7:    return BASE + 32'd36;
      default: return BASE;
    endcase
  endfunction

  task automatic model_next(output bit lit, output logic [31:0] val, output logic [31:0] npc,
                            output logic [2:0] nsc, output bit bad);
    logic [31:0] w;
    w   = mem[m_pc[7:2]];
    bad = 1'b0;
    npc = m_pc + 32'd4;
    if (w[31]) begin
      lit = 1'b1; val = {w[30:0], 1'b0}; nsc = 3'd0; m_pc += 32'd4;
    end else if (w[30]) begin
      lit = 1'b0; val = '0; nsc = 3'd0; bad = 1'b1;
    end else begin
      lit = 1'b0;
      val = (w >> (24 - 6 * m_idx)) & 32'h3f;
      nsc = 3'((m_idx + 1) % 5);
      m_idx++;
      if (m_idx == 5) begin m_idx = 0; m_pc += 32'd4; end
    end
  endtask

  task automatic step();
    bit          v, rq, hl, il, rd, rdy, deliver;
    logic        lit_o;
    logic [5:0]  syl_o;
    logic [31:0] lit_v, addr, pcs, tgt, word;
    logic [2:0]  scs;
    bit          e_lit, e_bad;
    logic [31:0] e_val, e_pc;
    logic [2:0]  e_sc;
    v = out_valid; rq = imem_req; hl = halted; il = illegal; addr = imem_addr;
    lit_o = out_is_lit; syl_o = out_syl; lit_v = out_lit; pcs = pc; scs = sc;

    check(hl == m_halt, "R7", "halted flag", 32'(hl), 32'(m_halt));
    check(il == m_ill, "R8", "illegal flag", 32'(il), 32'(m_ill));
    if (m_halt) check(!v && !rq, "R7", "activity while halted", {v, rq}, 0);
    if (m_ill)  check(!v && !rq, "R8", "activity while illegal", {v, rq}, 0);
    if (chk_redir) begin
      check(pcs == redir_prev, "R9", "pc after redirect", pcs, redir_prev);
      check(!v, "R9", "valid after redirect", 32'(v), 0);
      chk_redir = 0;
    end
    if (hold_chk) begin
      check(v && lit_o == h_lit && scs == h_sc && (h_lit ? lit_v == h_val : syl_o == h_syl),
            "R6", "stalled item changed", h_lit ? lit_v : 32'(syl_o), h_lit ? h_val : 32'(h_syl));
      hold_chk = 0;
    end

    rd = 0; tgt = '0;
    if (jmp_pend) begin
      rd = 1; tgt = jmp_tgt; jmp_pend = 0;
    end else if (m_halt || m_ill) begin
      stop_cnt++;
      if (stop_cnt >= 3) begin rd = 1; tgt = m_halt ? BASE + 32'd48 : BASE + 32'd64; end
    end else if ($urandom % 50 == 0) begin
      rd = 1;
      case ($urandom % 7)
        0: tgt = BASE;           1: tgt = BASE + 32'd4;  2: tgt = BASE + 32'd24;
        3: tgt = BASE + 32'd52;  4: tgt = BASE + 32'd64; 5: tgt = BASE + 32'd80;
        default: tgt = BASE + 32'd100;
      endcase
    end
    rdy = rd ? 1'b0 : ($urandom % 4 != 0);

    idle++;
    if (v && rdy) begin
      idle = 0;
      model_next(e_lit, e_val, e_pc, e_sc, e_bad);
      if (e_bad) check(0, "R8", "item issued from reserved word", 32'(syl_o), 0);
      else if (e_lit) begin
        check(lit_o == 1'b1, "R3", "literal kind", 32'(lit_o), 1);
        check(lit_v == e_val, "R3", "literal value", lit_v, e_val);
      end else begin
        check(lit_o == 1'b0, "R4", "syllable kind", 32'(lit_o), 0);
        check(32'(syl_o) == e_val, "R4", "syllable order", 32'(syl_o), e_val);
        if (e_val == 32'h0e) begin jmp_pend = 1; jmp_tgt = jmp_target(e_pc - 32'd4); end
        if (e_val == 32'h00) m_halt = 1;
      end
      check(pcs == e_pc, "R5", "pc during issue", pcs, e_pc);
      check(scs == e_sc, "R5", "sc during issue", 32'(scs), 32'(e_sc));
    end else if (v && !rd) begin
      hold_chk = 1; h_lit = lit_o; h_syl = syl_o; h_val = lit_v; h_sc = scs;
    end

    deliver = 0; word = $urandom;
    if (rq) begin
      check(!mb_busy, "R2", "second outstanding fetch", 32'(mb_busy), 0);
      check(addr == exp_fetch, "R2", "fetch address", addr, exp_fetch);
      if (first_req) begin
        check(addr == BASE, "R1", "first fetch address", addr, BASE);
        first_req = 0;
      end
    end
    if (mb_busy) begin
      if (mb_cnt == 0) begin
        deliver = 1; mb_busy = 0; word = mem[mb_addr[7:2]];
        if (!(mb_drop || rd) && word[31:30] == 2'b01) m_ill = 1;
      end else mb_cnt--;
    end
    if (rq) begin
      mb_busy = 1; mb_addr = addr; mb_cnt = $urandom % 3; mb_drop = 0;
      exp_fetch = addr + 32'd4;
    end
    if (rd) begin
      mb_drop = 1; exp_fetch = tgt; m_pc = tgt; m_idx = 0;
      m_halt = 0; m_ill = 0; stop_cnt = 0; chk_redir = 1; redir_prev = tgt; idle = 0;
    end

    redir_valid = rd; redir_pc = tgt; out_ready = rdy;
    imem_rvalid = deliver; imem_rdata = word;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = pack5(6'h01, 6'h01, 6'h01, 6'h01, 6'h01);
    mem[0]  = 32'hC040_4040;
    mem[1]  = pack5(6'h21, 6'h01, 6'h0C, 6'h1F, 6'h3F);
    mem[2]  = pack5(6'h08, 6'h09, 6'h0E, 6'h0D, 6'h0B);
    mem[3]  = 32'h4000_0000;
    mem[6]  = 32'hFFFF_FFFF;
    mem[7]  = pack5(6'h02, 6'h03, 6'h04, 6'h05, 6'h0E);
    mem[8]  = 32'h8000_0001;
    mem[9]  = pack5(6'h3A, 6'h00, 6'h25, 6'h25, 6'h25);
    mem[12] = 32'h8000_0000;
    mem[13] = pack5(6'h15, 6'h2A, 6'h33, 6'h04, 6'h07);
    mem[14] = 32'h7FFF_FFFF;
    for (int i = 16; i < 31; i++) begin
      if (i % 4 == 0) mem[i] = {1'b1, 31'(i * 32'h0123_4567)};
      else begin
        logic [5:0] s [5];
        for (int j = 0; j < 5; j++) begin
          s[j] = 6'(((i * 7 + j * 11) % 62) + 1);
          if (s[j] == 6'h0E) s[j] = 6'h0F;
        end
        mem[i] = pack5(s[0], s[1], s[2], s[3], s[4]);
      end
    end
    mem[31] = pack5(6'h0E, 6'h01, 6'h01, 6'h01, 6'h01);

    m_pc = BASE; m_idx = 0; m_halt = 0; m_ill = 0;
    mb_busy = 0; mb_drop = 0; mb_cnt = 0; mb_addr = '0; exp_fetch = BASE; first_req = 1;
    jmp_pend = 0; chk_redir = 0; hold_chk = 0; stop_cnt = 0; idle = 0;

    repeat (3) begin
      @(negedge clk);
      check(!out_valid && !imem_req, "R1", "valid/req in reset", {out_valid, imem_req}, 0);
      check(!halted && !illegal, "R1", "flags in reset", {halted, illegal}, 0);
      check(pc == BASE && sc == 3'd0, "R1", "pc in reset", pc, BASE);
    end
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      step();
      if (idle > 400) begin
        check(0, "R2", "watchdog: no progress", 32'(idle), 0);
        break;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule